// File: doc/BRIEF.md
# Addressing Mode and Privilege Unit

This unit holds the processor's current addressing mode (absolute, append or base-and-bound) and from it derives whether instructions run privileged or normal. It watches the instruction stream for two things: a field that chooses which pointer register qualifies the address, and a decoded flag that marks an instruction as privileged. When a privileged instruction arrives while execution is normal, it raises an illegal procedure fault.

In base-and-bound mode each computed address is offset by a base value and checked against a bound. An address at or past the bound gives a store fault and no valid address. In the other two modes the address passes through unchanged. All outputs are registered, so every result appears one clock after the inputs that caused it.

Top module: `amode_priv_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the mode is absolute (`mode_o` = 0), `priv_o` = 1, `use_ppr_o` = 1, `pr_idx_o` = 0, and `ea_vld_o`, `store_flt_o` and `ill_proc_o` are all 0.
- R2: A cycle with `trap_i` high sets the mode to absolute at the next edge. It wins over any transfer strobe in the same cycle.
- R3: With mode encoding absolute = 0, append = 1, base-and-bound = 2, the mode changes only on a trap or on `xfer_app_i`. When `xfer_app_i` is high the next mode is base-and-bound if `xfer_bar_i` is high and append otherwise. A `xfer_bar_i` without `xfer_app_i` has no effect.
- R4: `priv_o` is 1 when the next mode is absolute, or when `sdw_priv_i` is 1 and `ring_i` is 0. Otherwise it is 0. It is registered together with the mode.
- R5: Instruction bits are numbered from bit 0 as the most significant. On a valid instruction, `use_ppr_o` is set to the inverse of bit 29 (vector index WORD_W-30), and `pr_idx_o` takes bits 0..2 (vector bits WORD_W-1..WORD_W-3). Both hold when no instruction is valid.
- R6: A valid instruction with `insn_priv_i` high, presented while `priv_o` is 0, makes `ill_proc_o` 1 in the next cycle. Any other input makes it 0.
- R7: In absolute or append mode, a valid address comes out unchanged one cycle later with `ea_vld_o` high.
- R8: In base-and-bound mode, the output address is the input address plus `bar_base_i` times 2^BAR_SHIFT, taken modulo 2^ADDR_W.
- R9: In base-and-bound mode, a valid address is out of range when `bar_bound_i` times 2^BAR_SHIFT, minus the unrelocated address, is zero or negative. In that case `store_flt_o` is 1 for the next cycle and `ea_vld_o` is 0.
- R10: `store_flt_o` and `ea_vld_o` are never high together. A cycle without `addr_vld_i` leaves both low in the next cycle. Each fault output is a single-cycle pulse per triggering input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| trap_i | input | 1 | A fault or interrupt trap is taken |
| xfer_app_i | input | 1 | Transfer whose operand was obtained through the appending path |
| xfer_bar_i | input | 1 | Qualifies the transfer so that it enters base-and-bound mode |
| insn_vld_i | input | 1 | Instruction word is valid this cycle |
| insn_word_i | input | WORD_W | Instruction word, bit 0 as most significant |
| insn_priv_i | input | 1 | Decoded: instruction is privileged |
| sdw_priv_i | input | 1 | Descriptor of the executing segment marks it privileged |
| ring_i | input | RING_W | Current ring number |
| addr_vld_i | input | 1 | Computed address is valid |
| addr_i | input | ADDR_W | Computed (unrelocated) address |
| bar_base_i | input | BAR_W | Base, in units of 2^BAR_SHIFT words |
| bar_bound_i | input | BAR_W | Bound, in units of 2^BAR_SHIFT words |
| mode_o | output | 2 | Current addressing mode |
| priv_o | output | 1 | Privileged execution |
| use_ppr_o | output | 1 | Procedure pointer register selected |
| pr_idx_o | output | 3 | Selected pointer register number |
| ea_o | output | ADDR_W | Output address |
| ea_vld_o | output | 1 | Output address valid |
| store_flt_o | output | 1 | Store fault pulse (out of bound) |
| ill_proc_o | output | 1 | Illegal procedure fault pulse |

## Verification
The bench uses the defaults: WORD_W = 36, ADDR_W = 18, BAR_W = 9, BAR_SHIFT = 9, RING_W = 3. With these, a scaled bound covers the whole 2^18-word space in steps of 512. A high base pushes the relocated sum past 2^18, so the modulo wrap can be reached. The bench covers a bound of zero, which rejects every address, and the two addresses on either side of the bound. Because the ring field is three bits wide, the privilege rule sees nonzero rings, and the ring-0 case is weighted up.

// File: rtl/amp_pkg.sv
package amp_pkg;

    typedef enum logic [1:0] {
        AM_ABS = 2'd0,
        AM_APP = 2'd1,
        AM_BAR = 2'd2
    } amode_e;

    // instruction bit numbering counts from the most significant bit as 0
    localparam int unsigned PTR_SEL_BITNUM = 29;
    localparam int unsigned PR_FIELD_W     = 3;

endpackage

// File: rtl/amp_mode_ctl.sv
module amp_mode_ctl
    import amp_pkg::*;
#(
    parameter int unsigned WORD_W = 36,
    parameter int unsigned RING_W = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  trap_i,
    input  logic                  xfer_app_i,
    input  logic                  xfer_bar_i,
    input  logic                  insn_vld_i,
    input  logic [WORD_W-1:0]     insn_word_i,
    input  logic                  insn_priv_i,
    input  logic                  sdw_priv_i,
    input  logic [RING_W-1:0]     ring_i,
    output amode_e                mode_o,
    output logic                  priv_o,
    output logic                  use_ppr_o,
    output logic [PR_FIELD_W-1:0] pr_idx_o,
    output logic                  ill_proc_o
);

    localparam int unsigned SEL_POS = WORD_W - 1 - PTR_SEL_BITNUM;
    localparam int unsigned PR_HI   = WORD_W - 1;
    localparam int unsigned PR_LO   = WORD_W - PR_FIELD_W;

    typedef struct packed {
        amode_e                mode;
        logic                  priv;
        logic                  use_ppr;
        logic [PR_FIELD_W-1:0] pr_idx;
        logic                  ill;
    } ctl_t;

    ctl_t st_d, st_q;

    logic unused_word;
    assign unused_word = ^insn_word_i;

    always_comb begin
        st_d = st_q;

        // mode tracking: trap first, then a transfer through appending
        if (trap_i) begin
            st_d.mode = AM_ABS;
        end else if (xfer_app_i) begin
            st_d.mode = xfer_bar_i ? AM_BAR : AM_APP;
        end

        // privilege follows the mode being entered
        st_d.priv = (st_d.mode == AM_ABS) ||
                    (sdw_priv_i && (ring_i == '0));

        if (insn_vld_i) begin
            st_d.use_ppr = ~insn_word_i[SEL_POS];
            st_d.pr_idx  = insn_word_i[PR_HI:PR_LO];
        end

        st_d.ill = insn_vld_i && insn_priv_i && !st_q.priv;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.mode    <= AM_ABS;
            st_q.priv    <= 1'b1;
            st_q.use_ppr <= 1'b1;
            st_q.pr_idx  <= '0;
            st_q.ill     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o     = st_q.mode;
    assign priv_o     = st_q.priv;
    assign use_ppr_o  = st_q.use_ppr;
    assign pr_idx_o   = st_q.pr_idx;
    assign ill_proc_o = st_q.ill;

endmodule

// File: rtl/amp_bar_reloc.sv
module amp_bar_reloc
    import amp_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned BAR_W     = 9,
    parameter int unsigned BAR_SHIFT = 9
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  amode_e            mode_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BAR_W-1:0]  base_i,
    input  logic [BAR_W-1:0]  bound_i,
    output logic [ADDR_W-1:0] ea_o,
    output logic              ea_vld_o,
    output logic              store_flt_o
);

    localparam int unsigned EXT_W = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic              vld;
        logic              flt;
    } rel_t;

    rel_t st_d, st_q;

    logic [ADDR_W-1:0] base_sc;
    logic [EXT_W-1:0]  bound_sc;
    logic [EXT_W-1:0]  margin;
    logic              out_of_range;

    always_comb begin
        base_sc      = ADDR_W'(base_i) << BAR_SHIFT;
        bound_sc     = EXT_W'(bound_i) << BAR_SHIFT;
        margin       = bound_sc - {1'b0, addr_i};
        out_of_range = margin[EXT_W-1] || (margin == '0);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.flt = 1'b0;
        if (addr_vld_i) begin
            if (mode_i == AM_BAR) begin
                st_d.ea = addr_i + base_sc;
                if (out_of_range) begin
                    st_d.flt = 1'b1;
                end else begin
                    st_d.vld = 1'b1;
                end
            end else begin
                st_d.ea  = addr_i;
                st_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ea_o        = st_q.ea;
    assign ea_vld_o    = st_q.vld;
    assign store_flt_o = st_q.flt;

endmodule

// File: rtl/amode_priv_unit.sv
module amode_priv_unit
    import amp_pkg::*;
#(
    parameter int unsigned WORD_W    = 36,
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned BAR_W     = 9,
    parameter int unsigned BAR_SHIFT = 9,
    parameter int unsigned RING_W    = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trap_i,
    input  logic              xfer_app_i,
    input  logic              xfer_bar_i,
    input  logic              insn_vld_i,
    input  logic [WORD_W-1:0] insn_word_i,
    input  logic              insn_priv_i,
    input  logic              sdw_priv_i,
    input  logic [RING_W-1:0] ring_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BAR_W-1:0]  bar_base_i,
    input  logic [BAR_W-1:0]  bar_bound_i,
    output logic [1:0]        mode_o,
    output logic              priv_o,
    output logic              use_ppr_o,
    output logic [2:0]        pr_idx_o,
    output logic [ADDR_W-1:0] ea_o,
    output logic              ea_vld_o,
    output logic              store_flt_o,
    output logic              ill_proc_o
);

    amode_e mode_cur;

    amp_mode_ctl #(
        .WORD_W (WORD_W),
        .RING_W (RING_W)
    ) u_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trap_i      (trap_i),
        .xfer_app_i  (xfer_app_i),
        .xfer_bar_i  (xfer_bar_i),
        .insn_vld_i  (insn_vld_i),
        .insn_word_i (insn_word_i),
        .insn_priv_i (insn_priv_i),
        .sdw_priv_i  (sdw_priv_i),
        .ring_i      (ring_i),
        .mode_o      (mode_cur),
        .priv_o      (priv_o),
        .use_ppr_o   (use_ppr_o),
        .pr_idx_o    (pr_idx_o),
        .ill_proc_o  (ill_proc_o)
    );

    amp_bar_reloc #(
        .ADDR_W    (ADDR_W),
        .BAR_W     (BAR_W),
        .BAR_SHIFT (BAR_SHIFT)
    ) u_rel (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .mode_i      (mode_cur),
        .addr_vld_i  (addr_vld_i),
        .addr_i      (addr_i),
        .base_i      (bar_base_i),
        .bound_i     (bar_bound_i),
        .ea_o        (ea_o),
        .ea_vld_o    (ea_vld_o),
        .store_flt_o (store_flt_o)
    );

    assign mode_o = mode_cur;

endmodule

// File: rtl/amp_checker.sv
module amp_checker #(
    parameter int unsigned WORD_W    = 36,
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned BAR_W     = 9,
    parameter int unsigned BAR_SHIFT = 9,
    parameter int unsigned RING_W    = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              trap_i,
    input logic              xfer_app_i,
    input logic              insn_vld_i,
    input logic              insn_priv_i,
    input logic              addr_vld_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BAR_W-1:0]  bar_bound_i,
    input logic [1:0]        mode_o,
    input logic              priv_o,
    input logic              ea_vld_o,
    input logic              store_flt_o,
    input logic              ill_proc_o
);

    localparam int unsigned EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] lim;
    assign lim = EXT_W'(bar_bound_i) << BAR_SHIFT;

    assert_trap_abs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (mode_o == 2'd0));

    assert_abs_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd0 && !xfer_app_i && !trap_i) |=> (mode_o == 2'd0));

    assert_abs_priv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd0) |-> priv_o);

    assert_ill_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (insn_vld_i && insn_priv_i && !priv_o) |=> ill_proc_o);

    assert_bound_flt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_vld_i && mode_o == 2'd2 && {1'b0, addr_i} >= lim) |=> (store_flt_o && !ea_vld_o));

    assert_no_both_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(store_flt_o && ea_vld_o));

    assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !addr_vld_i |=> (!ea_vld_o && !store_flt_o));

endmodule

bind amode_priv_unit amp_checker #(
    .WORD_W    (WORD_W),
    .ADDR_W    (ADDR_W),
    .BAR_W     (BAR_W),
    .BAR_SHIFT (BAR_SHIFT),
    .RING_W    (RING_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trap_i      (trap_i),
    .xfer_app_i  (xfer_app_i),
    .insn_vld_i  (insn_vld_i),
    .insn_priv_i (insn_priv_i),
    .addr_vld_i  (addr_vld_i),
    .addr_i      (addr_i),
    .bar_bound_i (bar_bound_i),
    .mode_o      (mode_o),
    .priv_o      (priv_o),
    .ea_vld_o    (ea_vld_o),
    .store_flt_o (store_flt_o),
    .ill_proc_o  (ill_proc_o)
);

// File: tb/sim_amode_priv_unit.sv
module sim_amode_priv_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 36;
    localparam int ADDR_W     = 18;
    localparam int BAR_W      = 9;
    localparam int BAR_SHIFT  = 9;
    localparam int RING_W     = 3;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              trap_i = 1'b0, xfer_app_i = 1'b0, xfer_bar_i = 1'b0;
    logic              insn_vld_i = 1'b0, insn_priv_i = 1'b0, sdw_priv_i = 1'b0;
    logic [WORD_W-1:0] insn_word_i = '0;
    logic [RING_W-1:0] ring_i = '0;
    logic              addr_vld_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [BAR_W-1:0]  bar_base_i = '0, bar_bound_i = '0;
    logic [1:0]        mode_o;
    logic              priv_o, use_ppr_o, ea_vld_o, store_flt_o, ill_proc_o;
    logic [2:0]        pr_idx_o;
    logic [ADDR_W-1:0] ea_o;

    int total = 0;
    int bad   = 0;

    // expected state
    int m_mode, m_priv, m_ppr, m_idx, m_ea, m_vld, m_sf, m_ill;
    string tag_mode, tag_ea;

    always #(CLK_PERIOD/2) clk = ~clk;

    amode_priv_unit u0 (
        .clk_i(clk), .rst_ni(rst_ni), .trap_i(trap_i), .xfer_app_i(xfer_app_i),
        .xfer_bar_i(xfer_bar_i), .insn_vld_i(insn_vld_i), .insn_word_i(insn_word_i),
        .insn_priv_i(insn_priv_i), .sdw_priv_i(sdw_priv_i), .ring_i(ring_i),
        .addr_vld_i(addr_vld_i), .addr_i(addr_i), .bar_base_i(bar_base_i),
        .bar_bound_i(bar_bound_i), .mode_o(mode_o), .priv_o(priv_o),
        .use_ppr_o(use_ppr_o), .pr_idx_o(pr_idx_o), .ea_o(ea_o), .ea_vld_o(ea_vld_o),
        .store_flt_o(store_flt_o), .ill_proc_o(ill_proc_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int next_mode(int cur, bit tr, bit xa, bit xb);
        if (tr) return 0;
        if (xa) return xb ? 2 : 1;
        return cur;
    endfunction

    // one clock: drive at negedge, model, check at the following negedge
    task automatic step(input bit tr, input bit xa, input bit xb,
                        input bit iv, input logic [WORD_W-1:0] w, input bit ip,
                        input bit sp, input int rg,
                        input bit av, input int ad, input int bs, input int bd);
        int n_mode;
        longint lim;
        trap_i = tr; xfer_app_i = xa; xfer_bar_i = xb;
        insn_vld_i = iv; insn_word_i = w; insn_priv_i = ip;
        sdw_priv_i = sp; ring_i = RING_W'(rg);
        addr_vld_i = av; addr_i = ADDR_W'(ad);
        bar_base_i = BAR_W'(bs); bar_bound_i = BAR_W'(bd);

        n_mode   = next_mode(m_mode, tr, xa, xb);
        tag_mode = tr ? "R2" : "R3";
        m_ill    = (iv && ip && m_priv == 0) ? 1 : 0;
        tag_ea   = (m_mode == 2) ? "R8" : "R7";
        m_vld = 0; m_sf = 0;
        if (av) begin
            if (m_mode == 2) begin
                lim = longint'(bd) << BAR_SHIFT;
                if (lim - longint'(ad) <= 0) m_sf = 1;
                else begin
                    m_vld = 1;
                    m_ea  = (ad + (bs << BAR_SHIFT)) % (1 << ADDR_W);
                end
            end else begin
                m_vld = 1;
                m_ea  = ad;
            end
        end
        if (iv) begin
            m_ppr = w[WORD_W-30] ? 0 : 1;
            m_idx = int'(w[WORD_W-1 -: 3]);
        end
        m_mode = n_mode;
        m_priv = (n_mode == 0 || (sp && rg == 0)) ? 1 : 0;

        @(posedge clk);
        @(negedge clk);
        chk(int'(mode_o) == m_mode, tag_mode, "mode", mode_o, m_mode);
        chk(int'(priv_o) == m_priv, "R4", "priv", priv_o, m_priv);
        chk(int'(use_ppr_o) == m_ppr && int'(pr_idx_o) == m_idx, "R5", "ptrsel",
            {use_ppr_o, pr_idx_o}, (m_ppr << 3) | m_idx);
        chk(int'(ill_proc_o) == m_ill, "R6", "illproc", ill_proc_o, m_ill);
        chk(int'(store_flt_o) == m_sf, "R9", "storeflt", store_flt_o, m_sf);
        chk(int'(ea_vld_o) == m_vld, tag_ea, "eavld", ea_vld_o, m_vld);
        if (m_vld == 1)
            chk(int'(ea_o) == m_ea, tag_ea, "ea", ea_o, m_ea);
        chk(!(store_flt_o && ea_vld_o), "R10", "exclusive", {store_flt_o, ea_vld_o}, 0);
    endtask

    function automatic logic [WORD_W-1:0] mk_word(int pr, bit sel);
        logic [WORD_W-1:0] w;
        w = WORD_W'($urandom);
        w[WORD_W-1 -: 3] = 3'(pr);
        w[WORD_W-30] = sel;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(mode_o == 2'd0 && priv_o && use_ppr_o && pr_idx_o == 3'd0 &&
            !ea_vld_o && !store_flt_o && !ill_proc_o, "R1", "reset",
            {mode_o, priv_o, use_ppr_o, pr_idx_o, ea_vld_o, store_flt_o, ill_proc_o},
            {2'd0, 1'b1, 1'b1, 3'd0, 3'd0});
        rst_ni = 1'b1;
        m_mode = 0; m_priv = 1; m_ppr = 1; m_idx = 0; m_ea = 0;
        m_vld = 0; m_sf = 0; m_ill = 0;
        @(negedge clk);
        chk(mode_o == 2'd0 && priv_o && !ea_vld_o && !ill_proc_o, "R1", "post-reset",
            {mode_o, priv_o, ea_vld_o, ill_proc_o}, 3'b001 << 2);

        // R3: bar qualifier alone is ignored in absolute mode
        step(0,0,1, 0,'0,0, 0,1, 1,100,0,0);
        // R3: enter append; R4 ring 1 -> normal
        step(0,1,0, 0,'0,0, 1,1, 1,7,0,0);
        // R6: privileged insn in normal mode, R5 select pointer 5
        step(0,0,0, 1,mk_word(5,1),1, 1,1, 0,0,0,0);
        // R6: pulse clears
        step(0,0,0, 0,'0,0, 1,0, 0,0,0,0);
        // R3: enter base-and-bound mode, R4 ring 0 privileged descriptor
        step(0,1,1, 1,mk_word(2,0),0, 1,0, 0,0,0,0);
        // R9 boundary: bound 3 -> limit 1536
        step(0,0,0, 0,'0,0, 1,0, 1,1535,4,3);
        step(0,0,0, 0,'0,0, 1,0, 1,1536,4,3);
        // R9: zero bound rejects address 0
        step(0,0,0, 0,'0,0, 1,0, 1,0,4,0);
        // R8: wrap at 2^ADDR_W
        step(0,0,0, 0,'0,0, 1,0, 1,200000,511,511);
        // R2: trap wins over transfer
        step(1,1,1, 0,'0,0, 0,2, 1,5,0,0);

        for (int i = 0; i < 4000; i++) begin
            bit tr, xa, xb, iv, ip, sp, av;
            int rg, ad, bs, bd;
            tr = ($urandom_range(0, 15) == 0);
            xa = ($urandom_range(0, 5) == 0);
            xb = $urandom_range(0, 1) != 0;
            iv = $urandom_range(0, 1) != 0;
            ip = ($urandom_range(0, 3) == 0);
            sp = $urandom_range(0, 1) != 0;
            rg = ($urandom_range(0, 1) != 0) ? 0 : int'($urandom_range(0, 7));
            av = $urandom_range(0, 3) != 0;
            bs = int'($urandom_range(0, 511));
            bd = int'($urandom_range(0, 511));
            case ($urandom_range(0, 3))
                0: ad = (bd << BAR_SHIFT) - 1;
                1: ad = (bd << BAR_SHIFT);
                default: ad = int'($urandom_range(0, (1 << ADDR_W) - 1));
            endcase
            if (ad < 0) ad = 0;
            if (ad >= (1 << ADDR_W)) ad = (1 << ADDR_W) - 1;
            step(tr, xa, xb, iv, mk_word(int'($urandom_range(0, 7)), $urandom_range(0, 1) != 0),
                 ip, sp, rg, av, ad, bs, bd);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule